// File: doc/BRIEF.md
# Exchange Message Router for a Pipelined Sliding-Window Decoder

This block is the wiring and delay fabric around a chain of window processors in a pipelined decoder for spatially coupled codes. Each processor works on one sub-block per cycle. It swaps boundary messages with the processors that hold the neighbouring sub-blocks. The fabric owns every register between the processors. It moves each sub-block, with its valid, first and last flags, from one processor to the next. It routes the backward (right-to-left) and forward (left-to-right) exchange messages with the delay that the chosen schedule needs. It drives a zero wherever no real message exists.

The processors are outside the block and are seen only through per-stage ports. Two schedules are chosen at elaboration. The layered schedule puts two registers between neighbours, so each layer is updated every second cycle. The compact schedule moves a sub-block one processor per cycle. With the compact schedule, a count of extra internal processor stages lengthens both the data links and the exchange delay by one cycle per stage. For row-wise decoders, an output stage joins the right partial APP half of one sub-block with the left partial half of the next one.

Top module: `xr_exch_fabric`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `pi_valid`, `tail_valid` and `app_valid` are all 0.
- R2: The channel input reaches stage 0 one cycle after it is sampled. Stage k>0 receives the data output of stage k-1 after a link of LINK cycles: 2 for the layered schedule and 1+EXTRA for the compact one. The valid, first and last flags travel with the data. The data output of the last stage leaves on `tail_*` one cycle later.
- R3: The backward input of stage k equals the backward output of the same stage k, delayed by XD cycles.
- R4: The forward input of stage k equals the forward output of stage k-1 in the layered schedule, or of stage k-2 in the compact schedule, delayed by XD cycles.
- R5: A stage that has no forward source receives forward value 0. This is stage 0 in the layered schedule, and stages 0 and 1 in the compact one.
- R6: An exchange input is 0 when the stage's current slot is empty, or when the slot that produced the message XD cycles earlier was empty.
- R7: A slot flagged as the first of a block receives backward value 0. A slot flagged as the last of a block receives forward value 0.
- R8: The exchange delay XD is 1 in the layered schedule and 1+EXTRA in the compact schedule.
- R9: Two cycles after a valid slot sits at the last stage, `app_sum` is that slot's right APP half (zero-extended by one bit) plus the left APP half of the slot that follows it at the last stage, if that slot is valid. `app_valid` marks these cycles.
- R10: When the earlier slot was flagged last of its block, the left half is not added, and `app_sum` is the right half alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Channel sub-block present |
| in_first | input | 1 | Sub-block opens a block |
| in_last | input | 1 | Sub-block closes a block |
| in_data | input | DW | Channel sub-block payload |
| pr_dout | input | NPROC x DW | Data output of each processor |
| pr_r2l | input | NPROC x MW | Backward exchange output of each processor |
| pr_l2r | input | (NPROC-LJ) x MW | Forward exchange output of the processors that have a forward target |
| last_app_l | input | AW | Left partial APP of the last processor |
| last_app_r | input | AW | Right partial APP of the last processor |
| pi_valid | output | NPROC | Slot valid at each processor input |
| pi_first | output | NPROC | First-of-block flag per slot |
| pi_last | output | NPROC | Last-of-block flag per slot |
| pi_data | output | NPROC x DW | Data input to each processor |
| pi_r2l | output | NPROC x MW | Backward exchange input to each processor |
| pi_l2r | output | NPROC x MW | Forward exchange input to each processor |
| tail_valid | output | 1 | Chain output valid |
| tail_data | output | DW | Chain output payload |
| app_valid | output | 1 | Joined APP valid |
| app_sum | output | AW+1 | Joined APP value |

## Verification
The hardest case to reach is a message whose source slot was empty or on a block boundary, arriving at a live slot XD cycles later. The exchange delay is longer than one cycle only under the deeper compact setting, and the gating depends on both ends. To get there, the stimulus first streams back-to-back blocks of lengths one to four, so first, last and single-slot blocks reach every stage. It then punches pseudo-random gaps into the stream. Three instances run on the same stimulus: layered, compact, and compact with two extra stages. The stand-in processors tag every message with its stage and cycle, so each routed value shows where it came from and when.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic {SCH_LAYERED = 1'b0, SCH_COMPACT = 1'b1} sched_e;

  typedef struct packed {
    logic v;
    logic f;
    logic l;
  } slot_t;
endpackage

// File: rtl/xr_delay.sv
// Resettable shift line of N registers.
module xr_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [N];

  for (genvar s = 0; s < N; s++) begin : g_tap
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) sr[s] <= '0;
        else     sr[s] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) sr[s] <= '0;
        else     sr[s] <= sr[s-1];
      end
    end
  end

  assign q = sr[N-1];
endmodule

// File: rtl/xr_xport.sv
// Exchange input gate: a message is passed only when its source slot and the
// current slot are live and the current slot is not at a block edge.
module xr_xport #(
  parameter int MW = 16
) (
  input  logic [MW-1:0] msg,
  input  logic          src_v,
  input  logic          cur_v,
  input  logic          edge_blk,
  output logic [MW-1:0] xin
);
  always_comb begin
    xin = '0;
    if (src_v && cur_v && !edge_blk) xin = msg;
  end
endmodule

// File: rtl/xr_appjoin.sv
// Row-wise output stage: right half of slot t joined with left half of slot t+1.
module xr_appjoin #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cur_v,
  input  logic          cur_last,
  input  logic [AW-1:0] app_l,
  input  logic [AW-1:0] app_r,
  output logic          out_v,
  output logic [AW:0]   out_sum
);
  logic          hold_v;
  logic          hold_last;
  logic [AW-1:0] hold_r;
  logic [AW:0]   addend;

  always_comb begin
    addend = '0;
    if (cur_v && !hold_last) addend = {1'b0, app_l};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_last <= 1'b0;
      hold_r    <= '0;
      out_v     <= 1'b0;
      out_sum   <= '0;
    end else begin
      hold_v    <= cur_v;
      hold_last <= cur_last;
      hold_r    <= app_r;
      out_v     <= hold_v;
      out_sum   <= {1'b0, hold_r} + addend;
    end
  end
endmodule

// File: rtl/xr_exch_fabric.sv
module xr_exch_fabric
  import xr_pkg::*;
#(
  parameter int     NPROC = 4,
  parameter int     DW    = 8,
  parameter int     MW    = 16,
  parameter int     AW    = 12,
  parameter sched_e SCHED = SCH_COMPACT,
  parameter int     EXTRA = 0,
  localparam int    LJ    = (SCHED == SCH_LAYERED) ? 1 : 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_first,
  input  logic                        in_last,
  input  logic [DW-1:0]               in_data,
  input  logic [NPROC-1:0][DW-1:0]    pr_dout,
  input  logic [NPROC-1:0][MW-1:0]    pr_r2l,
  input  logic [NPROC-LJ-1:0][MW-1:0] pr_l2r,
  input  logic [AW-1:0]               last_app_l,
  input  logic [AW-1:0]               last_app_r,
  output logic [NPROC-1:0]            pi_valid,
  output logic [NPROC-1:0]            pi_first,
  output logic [NPROC-1:0]            pi_last,
  output logic [NPROC-1:0][DW-1:0]    pi_data,
  output logic [NPROC-1:0][MW-1:0]    pi_r2l,
  output logic [NPROC-1:0][MW-1:0]    pi_l2r,
  output logic                        tail_valid,
  output logic [DW-1:0]               tail_data,
  output logic                        app_valid,
  output logic [AW:0]                 app_sum
);
  localparam int LINK = (SCHED == SCH_LAYERED) ? 2 : 1 + EXTRA;
  localparam int XD   = (SCHED == SCH_LAYERED) ? 1 : 1 + EXTRA;

  slot_t slot [NPROC];
  slot_t tail_slot;

  // Data and flag links
  for (genvar k = 0; k < NPROC; k++) begin : g_link
    if (k == 0) begin : g_entry
      xr_delay #(.W(3), .N(1)) u_meta (
        .clk(clk), .rst(rst), .d({in_valid, in_first, in_last}), .q(slot[k]));
      xr_delay #(.W(DW), .N(1)) u_dat (
        .clk(clk), .rst(rst), .d(in_data), .q(pi_data[k]));
    end else begin : g_chain
      xr_delay #(.W(3), .N(LINK)) u_meta (
        .clk(clk), .rst(rst), .d(slot[k-1]), .q(slot[k]));
      xr_delay #(.W(DW), .N(LINK)) u_dat (
        .clk(clk), .rst(rst), .d(pr_dout[k-1]), .q(pi_data[k]));
    end
    assign pi_valid[k] = slot[k].v;
    assign pi_first[k] = slot[k].f;
    assign pi_last[k]  = slot[k].l;
  end

  // Backward exchange: loops back to the same stage
  for (genvar k = 0; k < NPROC; k++) begin : g_bwd
    logic [MW-1:0] msg_d;
    logic          src_d;
    xr_delay #(.W(MW), .N(XD)) u_msg (
      .clk(clk), .rst(rst), .d(pr_r2l[k]), .q(msg_d));
    xr_delay #(.W(1), .N(XD)) u_src (
      .clk(clk), .rst(rst), .d(slot[k].v), .q(src_d));
    xr_xport #(.MW(MW)) u_gate (
      .msg(msg_d), .src_v(src_d), .cur_v(slot[k].v),
      .edge_blk(slot[k].f), .xin(pi_r2l[k]));
  end

  // Forward exchange: from LJ stages upstream
  for (genvar k = 0; k < NPROC; k++) begin : g_fwd
    if (k < LJ) begin : g_none
      assign pi_l2r[k] = '0;
    end else begin : g_route
      logic [MW-1:0] msg_d;
      logic          src_d;
      xr_delay #(.W(MW), .N(XD)) u_msg (
        .clk(clk), .rst(rst), .d(pr_l2r[k-LJ]), .q(msg_d));
      xr_delay #(.W(1), .N(XD)) u_src (
        .clk(clk), .rst(rst), .d(slot[k-LJ].v), .q(src_d));
      xr_xport #(.MW(MW)) u_gate (
        .msg(msg_d), .src_v(src_d), .cur_v(slot[k].v),
        .edge_blk(slot[k].l), .xin(pi_l2r[k]));
    end
  end

  // Chain output
  xr_delay #(.W(3), .N(1)) u_tail_meta (
    .clk(clk), .rst(rst), .d(slot[NPROC-1]), .q(tail_slot));
  xr_delay #(.W(DW), .N(1)) u_tail_dat (
    .clk(clk), .rst(rst), .d(pr_dout[NPROC-1]), .q(tail_data));
  assign tail_valid = tail_slot.v;

  // APP join
  xr_appjoin #(.AW(AW)) u_join (
    .clk(clk), .rst(rst),
    .cur_v(slot[NPROC-1].v), .cur_last(slot[NPROC-1].l),
    .app_l(last_app_l), .app_r(last_app_r),
    .out_v(app_valid), .out_sum(app_sum));
endmodule

// File: rtl/xr_exch_fabric_chk.sv
module xr_exch_fabric_chk #(
  parameter int NPROC = 4,
  parameter int DW    = 8,
  parameter int MW    = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_first,
  input logic                     in_last,
  input logic [DW-1:0]            in_data,
  input logic [NPROC-1:0]         pi_valid,
  input logic [NPROC-1:0]         pi_first,
  input logic [NPROC-1:0]         pi_last,
  input logic [NPROC-1:0][DW-1:0] pi_data,
  input logic [NPROC-1:0][MW-1:0] pi_r2l,
  input logic [NPROC-1:0][MW-1:0] pi_l2r,
  input logic                     tail_valid,
  input logic                     app_valid
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pi_valid == '0 && !tail_valid && !app_valid));

  a_r2_entry: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pi_valid[0] == $past(in_valid) &&
                     (!pi_valid[0] || (pi_first[0] == $past(in_first) &&
                                       pi_last[0] == $past(in_last) &&
                                       pi_data[0] == $past(in_data)))));

  a_r9_join_source: assert property (@(posedge clk) disable iff (rst)
    app_valid |-> $past(pi_valid[NPROC-1], 2));

  for (genvar k = 0; k < NPROC; k++) begin : g_stage
    a_r6_empty_slot_quiet: assert property (@(posedge clk) disable iff (rst)
      !pi_valid[k] |-> (pi_r2l[k] == '0 && pi_l2r[k] == '0));
    a_r7_first_no_bwd: assert property (@(posedge clk) disable iff (rst)
      (pi_valid[k] && pi_first[k]) |-> pi_r2l[k] == '0);
    a_r7_last_no_fwd: assert property (@(posedge clk) disable iff (rst)
      (pi_valid[k] && pi_last[k]) |-> pi_l2r[k] == '0);
  end
endmodule

bind xr_exch_fabric xr_exch_fabric_chk #(.NPROC(NPROC), .DW(DW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
  .in_last(in_last), .in_data(in_data), .pi_valid(pi_valid),
  .pi_first(pi_first), .pi_last(pi_last), .pi_data(pi_data),
  .pi_r2l(pi_r2l), .pi_l2r(pi_l2r), .tail_valid(tail_valid),
  .app_valid(app_valid));

// File: tb/sim_lane.sv
// One configuration of the fabric with tagging stand-in processors and a
// history-based reference model.
module sim_lane
  import xr_pkg::*;
#(
  parameter sched_e SCHED = SCH_COMPACT,
  parameter int     EXTRA = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       in_v,
  input logic       in_f,
  input logic       in_l,
  input logic [7:0] in_id,
  input int         cyc
);
  localparam int N    = 4;
  localparam int LJ   = (SCHED == SCH_LAYERED) ? 1 : 2;
  localparam int LINK = (SCHED == SCH_LAYERED) ? 2 : 1 + EXTRA;
  localparam int XD   = (SCHED == SCH_LAYERED) ? 1 : 1 + EXTRA;
  localparam int HN   = 1024;

  int nchk = 0;
  int nfail = 0;

  logic [N-1:0][7:0]     pr_dout;
  logic [N-1:0][15:0]    pr_r2l;
  logic [N-LJ-1:0][15:0] pr_l2r;
  logic [11:0]           app_l, app_r;
  logic [N-1:0]          pi_valid, pi_first, pi_last;
  logic [N-1:0][7:0]     pi_data;
  logic [N-1:0][15:0]    pi_r2l, pi_l2r;
  logic                  tail_valid, app_valid;
  logic [7:0]            tail_data;
  logic [12:0]           app_sum;

  xr_exch_fabric #(.NPROC(N), .DW(8), .MW(16), .AW(12), .SCHED(SCHED), .EXTRA(EXTRA)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_v), .in_first(in_f), .in_last(in_l),
    .in_data(in_id), .pr_dout(pr_dout), .pr_r2l(pr_r2l), .pr_l2r(pr_l2r),
    .last_app_l(app_l), .last_app_r(app_r), .pi_valid(pi_valid),
    .pi_first(pi_first), .pi_last(pi_last), .pi_data(pi_data),
    .pi_r2l(pi_r2l), .pi_l2r(pi_l2r), .tail_valid(tail_valid),
    .tail_data(tail_data), .app_valid(app_valid), .app_sum(app_sum));

  function automatic logic [15:0] tag(int kind, int k, int m);
    return {2'(kind), 4'(k), 10'(m)};
  endfunction

  // Stand-in processors: data passes through, messages carry stage and cycle.
  always_comb begin
    for (int k = 0; k < N; k++) begin
      pr_dout[k] = pi_data[k];
      pr_r2l[k]  = tag(1, k, cyc);
    end
    for (int k = 0; k < N - LJ; k++) pr_l2r[k] = tag(2, k, cyc);
    app_r = {pi_data[N-1], 4'h5};
    app_l = {4'h0, pi_data[N-1]};
  end

  logic       hv [HN];
  logic       hf [HN];
  logic       hl [HN];
  logic [7:0] hid [HN];

  initial begin
    for (int i = 0; i < HN; i++) begin
      hv[i] = 1'b0; hf[i] = 1'b0; hl[i] = 1'b0; hid[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (cyc >= 0 && cyc < HN) begin
      hv[cyc] <= in_v; hf[cyc] <= in_f; hl[cyc] <= in_l; hid[cyc] <= in_id;
    end
  end

  function automatic int hidx(int k, int m);
    return m - 1 - k * LINK;
  endfunction
  function automatic logic sv(int k, int m);
    int i = hidx(k, m);
    return (i >= 0 && i < HN) ? hv[i] : 1'b0;
  endfunction
  function automatic logic sf(int k, int m);
    int i = hidx(k, m);
    return (i >= 0 && i < HN) ? hf[i] : 1'b0;
  endfunction
  function automatic logic sl(int k, int m);
    int i = hidx(k, m);
    return (i >= 0 && i < HN) ? hl[i] : 1'b0;
  endfunction
  function automatic logic [7:0] sid(int k, int m);
    int i = hidx(k, m);
    return (i >= 0 && i < HN) ? hid[i] : 8'h0;
  endfunction

  task automatic chk(string req, string what, int k, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s sched=%0d extra=%0d cyc=%0d stage=%0d %s: actual %h expected %h",
               req, SCHED, EXTRA, cyc, k, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int m;
    m = cyc;
    if (m >= 1 && rst) begin
      chk("R1", "valid vector", 0, {29'h0, pi_valid[2:0] | {2'b0, pi_valid[3]}}, 32'h0);
      chk("R1", "tail/app valid", 0, {30'h0, tail_valid, app_valid}, 32'h0);
    end else if (m >= 1) begin
      for (int k = 0; k < N; k++) begin
        logic        v;
        logic [15:0] eb, ef;
        string       rb, rf;
        int          src;
        v = sv(k, m);
        chk("R2", "valid", k, {31'h0, pi_valid[k]}, {31'h0, v});
        if (v) begin
          chk("R2", "data", k, {24'h0, pi_data[k]}, {24'h0, sid(k, m)});
          chk("R2", "flags", k, {30'h0, pi_first[k], pi_last[k]}, {30'h0, sf(k, m), sl(k, m)});
        end
        // backward
        eb = '0;
        rb = (EXTRA > 0) ? "R8" : "R3";
        if (!v) rb = "R6";
        else if (sf(k, m)) rb = "R7";
        else if (!sv(k, m - XD)) rb = "R6";
        else eb = tag(1, k, m - XD);
        chk(rb, "backward in", k, {16'h0, pi_r2l[k]}, {16'h0, eb});
        // forward
        ef = '0;
        src = k - LJ;
        rf = (EXTRA > 0) ? "R8" : "R4";
        if (src < 0) rf = "R5";
        else if (!v) rf = "R6";
        else if (sl(k, m)) rf = "R7";
        else if (!sv(src, m - XD)) rf = "R6";
        else ef = tag(2, src, m - XD);
        chk(rf, "forward in", k, {16'h0, pi_l2r[k]}, {16'h0, ef});
      end
      chk("R2", "tail valid", N, {31'h0, tail_valid}, {31'h0, sv(N-1, m-1)});
      if (sv(N-1, m-1))
        chk("R2", "tail data", N, {24'h0, tail_data}, {24'h0, sid(N-1, m-1)});
      chk("R9", "app valid", N, {31'h0, app_valid}, {31'h0, sv(N-1, m-2)});
      if (sv(N-1, m-2)) begin
        logic [12:0] es;
        es = {1'b0, sid(N-1, m-2), 4'h5};
        if (sv(N-1, m-1) && !sl(N-1, m-2)) es = es + {5'h0, sid(N-1, m-1)};
        chk(sl(N-1, m-2) ? "R10" : "R9", "app sum", N, {19'h0, app_sum}, {19'h0, es});
      end
    end
  end
endmodule

// File: tb/sim_xr_exch_fabric.sv
module sim_xr_exch_fabric;
  import xr_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_v = 1'b0, in_f = 1'b0, in_l = 1'b0;
  logic [7:0] in_id = '0;
  int         cyc = 0;
  bit         done = 1'b0;
  int         wd_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sim_lane #(.SCHED(SCH_COMPACT), .EXTRA(0)) lane_c0 (
    .clk(clk), .rst(rst), .in_v(in_v), .in_f(in_f), .in_l(in_l), .in_id(in_id), .cyc(cyc));
  sim_lane #(.SCHED(SCH_COMPACT), .EXTRA(2)) lane_c2 (
    .clk(clk), .rst(rst), .in_v(in_v), .in_f(in_f), .in_l(in_l), .in_id(in_id), .cyc(cyc));
  sim_lane #(.SCHED(SCH_LAYERED), .EXTRA(0)) lane_ly (
    .clk(clk), .rst(rst), .in_v(in_v), .in_f(in_f), .in_l(in_l), .in_id(in_id), .cyc(cyc));

  task automatic report;
    int c, f;
    c = lane_c0.nchk + lane_c2.nchk + lane_ly.nchk + wd_fail;
    f = lane_c0.nfail + lane_c2.nfail + lane_ly.nfail + wd_fail;
    $display("End of test - %0d assertions evaluated, %0d failures", c, f);
  endtask

  // Stimulus: blocks of length 1..4, dense first, then with gaps (R1..R10)
  initial begin
    logic [15:0] lfsr;
    int          pos, blen, nblk;
    lfsr = 16'hACE1; pos = 0; blen = 1; nblk = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    while (cyc < 620) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cyc < 590 && (cyc < 250 || lfsr[0] || lfsr[3])) begin
        in_v = 1'b1;
        in_f = (pos == 0);
        in_l = (pos == blen - 1);
        in_id = in_id + 8'd1;
        if (pos == blen - 1) begin
          pos = 0; nblk++;
          blen = 1 + ((cyc < 250) ? (nblk % 4) : int'(lfsr[5:4]));
        end else pos++;
      end else begin
        in_v = 1'b0; in_f = 1'b0; in_l = 1'b0;
      end
    end
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #50us;
    if (!done) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end
endmodule